// File: doc/BRIEF.md
# Clocked Serial Shift Port

This block moves one byte at a time over a three-wire synchronous serial link. The transfer clock comes from one of two places. In internal mode the block divides the system clock and drives the clock pin itself. In external mode it follows a clock pin driven by the link partner. A single shift register is used for both directions. Outgoing bits leave on the data-out pin on each falling transfer-clock edge. Incoming bits are sampled on each rising edge and shifted into the register at the opposite end. After eight rising edges, a one-cycle interrupt request marks the end of the byte.

Software-side logic configures the block through a small write/read port. Register select 0 is the mode register. Register select 1 is the shift register. Writing the shift register starts a transfer. To receive only, software first writes all ones so that the line is left high. A half-duplex option takes receive data from the data-out pad instead of the data-in pin, so one wire can carry both directions. The mode register also chooses:

- the bit order;
- the internal clock rate;
- whether the pins are handed to the serial function at all.

Top module: `sio_shift_port`

## Requirements
- R1: After reset the mode register reads 0, the shift register reads 0, irq is 0, sclk_out is 1, and both sclk_oe and dout_oe are 0.
- R2: Writing the shift register (wr_sel=1) loads the byte and starts a transfer of exactly 8 bits. irq is high for exactly one cycle. In internal mode, irq goes high 16*H cycles after the write edge.
- R3: Mode bit 2 = 1 selects the internal clock. Mode bits [1:0] choose the half period H = PRESCALE times 2, 8, 16 or 32 system clocks (codes 0..3, i.e. divide by 4, 16, 32, 64). The first falling edge comes H cycles after the write. sclk_out rests high whenever no transfer runs, including after the 8th rising edge.
- R4: dout changes only on falling transfer-clock edges during a transfer. With mode bit 4 = 0, bit 0 is sent first.
- R5: With mode bit 4 = 1, bit 7 is sent first.
- R6: On each rising edge one received bit enters the shift register. After a transfer, the first received bit sits in bit 0 (LSB-first) or in bit 7 (MSB-first), and the register reads back the received byte.
- R7: With mode bit 5 = 1, received bits come from dout_pad and din is ignored. With mode bit 5 = 0 they come from din.
- R8: With mode bit 2 = 0, the block shifts on synchronized edges of sclk_in and never drives the clock pin. Clock edges after the 8th rising edge change neither the shift register, nor dout, nor irq.
- R9: With mode bit 3 = 0, sclk_oe and dout_oe stay 0. With bit 3 = 1 and the internal clock, dout_oe is 1 only while a transfer runs, so dout goes high impedance at completion. With bit 3 = 1 and the external clock, dout_oe stays 1.
- R10: rd_sel = 0 returns the 6 mode bits with the upper bits zero. rd_sel = 1 returns the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 mode, 1 shift register |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 1 | Read source: 0 mode, 1 shift register |
| rd_data | output | DATA_W | Read data |
| sclk_in | input | 1 | Clock pin value (external clock) |
| sclk_out | output | 1 | Clock pin drive value |
| sclk_oe | output | 1 | Clock pin output enable |
| din | input | 1 | Serial data-in pin |
| dout_pad | input | 1 | Value seen on the data-out pad (half-duplex receive) |
| dout | output | 1 | Serial data-out drive value |
| dout_oe | output | 1 | Data-out output enable |
| irq | output | 1 | One-cycle end-of-transfer request |

## Verification
The bench builds the block with PRESCALE = 1 and SYNC_STAGES = 2. This keeps all four internal rates short: a full byte takes 32 to 512 cycles. Every divider code can therefore be timed exactly, from the write edge to the first falling edge and to irq. Two synchronizer stages make external-clock edges take effect three cycles after the pin moves. The bench holds each external half period for six cycles, so every pin edge is acted on before the next one arrives.

// File: rtl/sio_pkg.sv
package sio_pkg;

    // Mode register layout, bit 5 down to bit 0
    typedef struct packed {
        logic       rx_from_dout;  // 5: receive from data-out pad
        logic       msb_first;     // 4: bit order
        logic       pins_on;       // 3: pins belong to the serial function
        logic       int_clk;       // 2: internally generated transfer clock
        logic [1:0] div_code;      // 1:0 internal rate
    } sio_mode_t;

    localparam int MODE_W = $bits(sio_mode_t);

    // Half period of the internal clock in system clocks, before prescale
    function automatic int half_base(input logic [1:0] code);
        case (code)
            2'd0:    return 2;
            2'd1:    return 8;
            2'd2:    return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/sio_clk_divider.sv
module sio_clk_divider #(
    parameter int PRESCALE = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] div_code,
    output logic       sclk,
    output logic       fall_evt,
    output logic       rise_evt
);
    import sio_pkg::*;

    localparam int MAX_HALF = 32 * PRESCALE;
    localparam int CW       = $clog2(MAX_HALF) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } div_st_t;

    div_st_t       st_d, st_q;
    logic [CW-1:0] half_len;
    logic          at_term;

    always_comb begin
        half_len = CW'(half_base(div_code) * PRESCALE);
        at_term  = (st_q.cnt == half_len - CW'(1));
        fall_evt = run & ~restart & at_term & st_q.sclk;
        rise_evt = run & ~restart & at_term & ~st_q.sclk;
        st_d     = st_q;
        if (restart || !run) begin
            st_d.cnt  = '0;
            st_d.sclk = 1'b1;
        end else if (at_term) begin
            st_d.cnt  = '0;
            st_d.sclk = ~st_q.sclk;
        end else begin
            st_d.cnt  = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '0;
            st_q.sclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.sclk;

endmodule

// File: rtl/sio_edge_sync.sv
module sio_edge_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], pin};
        rise = sh_q[STAGES-1] & ~sh_q[STAGES];
        fall = ~sh_q[STAGES-1] & sh_q[STAGES];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {W{IDLE}};
        else        sh_q <= sh_d;
    end

endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port #(
    parameter int DATA_W      = 8,
    parameter int PRESCALE    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              din,
    input  logic              dout_pad,
    output logic              dout,
    output logic              dout_oe,
    output logic              irq
);
    import sio_pkg::*;

    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        sio_mode_t         mode;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
        logic              dout;
        logic              irq;
    } port_st_t;

    port_st_t st_d, st_q;

    logic load;
    logic int_sclk, int_fall, int_rise;
    logic ext_fall, ext_rise;
    logic fall_evt, rise_evt, rx_bit;

    assign load = wr_en & wr_sel;

    sio_clk_divider #(.PRESCALE(PRESCALE)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.busy & st_q.mode.int_clk),
        .restart  (load),
        .div_code (st_q.mode.div_code),
        .sclk     (int_sclk),
        .fall_evt (int_fall),
        .rise_evt (int_rise)
    );

    sio_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sclk_in),
        .rise  (ext_rise),
        .fall  (ext_fall)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        fall_evt = st_q.mode.int_clk ? int_fall : ext_fall;
        rise_evt = st_q.mode.int_clk ? int_rise : ext_rise;
        rx_bit   = st_q.mode.rx_from_dout ? dout_pad : din;

        if (st_q.busy) begin
            if (fall_evt) begin
                st_d.dout = st_q.mode.msb_first ? st_q.shreg[DATA_W-1] : st_q.shreg[0];
            end
            if (rise_evt) begin
                if (st_q.mode.msb_first) st_d.shreg = {st_q.shreg[DATA_W-2:0], rx_bit};
                else                     st_d.shreg = {rx_bit, st_q.shreg[DATA_W-1:1]};
                if (st_q.cnt == '0) begin
                    st_d.busy = 1'b0;
                    st_d.irq  = 1'b1;
                end else begin
                    st_d.cnt  = st_q.cnt - CNT_W'(1);
                end
            end
        end

        if (wr_en) begin
            if (wr_sel) begin
                st_d.shreg = wr_data;
                st_d.cnt   = CNT_W'(DATA_W - 1);
                st_d.busy  = 1'b1;
            end else begin
                st_d.mode  = sio_mode_t'(wr_data[MODE_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= '0;
            st_q.shreg <= '0;
            st_q.cnt   <= '0;
            st_q.busy  <= 1'b0;
            st_q.dout  <= 1'b1;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data  = rd_sel ? st_q.shreg : DATA_W'(st_q.mode);
        sclk_out = st_q.mode.int_clk ? int_sclk : 1'b1;
        sclk_oe  = st_q.mode.pins_on & st_q.mode.int_clk;
        dout     = st_q.dout;
        dout_oe  = st_q.mode.pins_on & (st_q.mode.int_clk ? st_q.busy : 1'b1);
        irq      = st_q.irq;
    end

    // Observation points for the bound checker
    logic              busy_w;
    logic [MODE_W-1:0] mode_w;
    assign busy_w = st_q.busy;
    assign mode_w = st_q.mode;

endmodule

// File: rtl/sio_shift_port_checker.sv
module sio_shift_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       irq,
    input logic       sclk_out,
    input logic       dout,
    input logic       dout_oe,
    input logic       busy,
    input logic [5:0] mode
);
    // R2: the request lasts one cycle
    p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R2: a transfer only ends with a request
    p_end_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    // R3: the clock rests high outside a transfer
    p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_out);

    // R4: data-out moves only during a transfer
    p_dout_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> $past(busy));

    // R9: no data-out drive unless the pins are given to the port
    p_dout_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> mode[3]);

endmodule

bind sio_shift_port sio_shift_port_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq      (irq),
    .sclk_out (sclk_out),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .busy     (busy_w),
    .mode     (mode_w)
);

// File: tb/sio_shift_port_test.sv
module sio_shift_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       sclk_in = 1'b1;
    logic       sclk_out, sclk_oe;
    logic       din = 1'b0;
    logic       dout_pad = 1'b0;
    logic       dout, dout_oe, irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sio_shift_port #(.DATA_W(8), .PRESCALE(1), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .sclk_in(sclk_in), .sclk_out(sclk_out),
        .sclk_oe(sclk_oe), .din(din), .dout_pad(dout_pad), .dout(dout),
        .dout_oe(dout_oe), .irq(irq)
    );

    always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1 d = rd_data;
    endtask

    task automatic wait_sclk(input logic lvl);
        for (int n = 0; n < 1000 && sclk_out !== lvl; n++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(1'b0, v); chk(v == 8'h00, "R1 mode", v, 8'h00);
        rd(1'b1, v); chk(v == 8'h00, "R1 shreg", v, 8'h00);
        chk(irq == 1'b0 && sclk_out == 1'b1, "R1 irq/sclk", {irq, sclk_out}, 2'b01);
        chk(sclk_oe == 1'b0 && dout_oe == 1'b0, "R1 oe", {sclk_oe, dout_oe}, 0);
    endtask

    task automatic t_read;
        logic [7:0] v;
        wr(1'b0, 8'hFF);
        rd(1'b0, v); chk(v == 8'h3F, "R10 mode readback", v, 8'h3F);
        wr(1'b0, 8'h00);
        rd(1'b0, v); chk(v == 8'h00, "R10 mode clear", v, 8'h00);
    endtask

    // R2/R3: exact timing of each internal rate
    task automatic t_timing;
        for (int code = 0; code < 4; code++) begin
            int h;
            int first_fall;
            int irq_at;
            int base;
            h = (code == 0) ? 2 : (code == 1) ? 8 : (code == 2) ? 16 : 32;
            first_fall = -1;
            irq_at = -1;
            wr(1'b0, 8'h0C | 8'(code));
            base = irq_cnt;
            wr(1'b1, 8'h00);
            for (int c = 0; c < 1200; c++) begin
                if (sclk_out == 1'b0 && first_fall < 0) first_fall = c;
                if (irq) begin irq_at = c; break; end
                @(negedge clk);
            end
            chk(first_fall == h, "R3 first falling edge", first_fall, h);
            chk(irq_at == 16 * h, "R2 irq time", irq_at, 16 * h);
            @(negedge clk);
            chk(irq == 1'b0 && irq_cnt == base + 1, "R2 one-cycle irq", irq_cnt - base, 1);
        end
        repeat (40) @(negedge clk);
        chk(sclk_out == 1'b1, "R3 clock parks high", sclk_out, 1);
    endtask

    task automatic t_int_xfer(input logic [7:0] mode, input logic [7:0] tx,
                              input logic [7:0] rx, input string req);
        logic [7:0] got, exp_tx, v;
        int base;
        logic b;
        wr(1'b0, mode);
        base = irq_cnt;
        wr(1'b1, tx);
        for (int i = 0; i < 8; i++) begin
            wait_sclk(1'b0);
            got[i]    = dout;
            exp_tx[i] = mode[4] ? tx[7-i] : tx[i];
            b         = mode[4] ? rx[7-i] : rx[i];
            if (mode[5]) begin dout_pad = b; din = ~b; end
            else         begin din = b; dout_pad = ~b; end
            if (i == 3) chk(dout_oe == mode[3], "R9 oe during transfer", dout_oe, mode[3]);
            wait_sclk(1'b1);
        end
        repeat (4) @(negedge clk);
        chk(got == exp_tx, {req, " tx order"}, got, exp_tx);
        rd(1'b1, v);
        chk(v == rx, {req, " rx byte"}, v, rx);
        chk(irq_cnt == base + 1, "R2 irq count", irq_cnt - base, 1);
        chk(dout_oe == 1'b0 && sclk_out == 1'b1, "R9 hi-z after done", {dout_oe, sclk_out}, 1);
    endtask

    task automatic t_ext;
        logic [7:0] got, v, tx, rx;
        int base;
        logic held;
        tx = 8'hC3; rx = 8'h5A;
        wr(1'b0, 8'h08);
        chk(sclk_oe == 1'b0 && dout_oe == 1'b1, "R9 ext pins", {sclk_oe, dout_oe}, 1);
        base = irq_cnt;
        wr(1'b1, tx);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0;
            repeat (6) @(negedge clk);
            got[i] = dout;
            din = rx[i]; dout_pad = ~rx[i];
            sclk_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        chk(got == tx, "R8 ext tx LSB first", got, tx);
        rd(1'b1, v);
        chk(v == rx, "R8 ext rx byte", v, rx);
        chk(irq_cnt == base + 1, "R8 ext irq", irq_cnt - base, 1);
        held = dout;
        din = ~din;
        for (int i = 0; i < 3; i++) begin
            sclk_in = 1'b0; repeat (6) @(negedge clk);
            sclk_in = 1'b1; repeat (6) @(negedge clk);
        end
        rd(1'b1, v);
        chk(v == rx, "R8 shreg after extra edges", v, rx);
        chk(dout == held, "R8 dout after extra edges", dout, held);
        chk(irq_cnt == base + 1, "R8 no extra irq", irq_cnt - base, 1);
    endtask

    task automatic t_pins_off;
        int base;
        wr(1'b0, 8'h04);
        base = irq_cnt;
        wr(1'b1, 8'h81);
        repeat (10) @(negedge clk);
        chk(sclk_oe == 1'b0 && dout_oe == 1'b0, "R9 pins off", {sclk_oe, dout_oe}, 0);
        repeat (40) @(negedge clk);
        chk(irq_cnt == base + 1, "R2 transfer with pins off", irq_cnt - base, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_read;
        t_timing;
        t_int_xfer(8'h0C, 8'hA5, 8'h3C, "R4 R6 LSB first");
        t_int_xfer(8'h1C, 8'hA5, 8'h96, "R5 R6 MSB first");
        t_int_xfer(8'h2D, 8'h1E, 8'hE2, "R7 half-duplex");
        t_int_xfer(8'h0C, 8'hFF, 8'h71, "R7 din path");
        t_ext;
        t_pins_off;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule